// File: doc/BRIEF.md
# Table-Decoded Interrupt Aggregator

This block gathers interrupt events from nine source groups, each 32 bits wide, into nine level-sensitive interrupt lines. Every group owns a mask register, which selects the source bits that may record an event, and a pending register. A pending bit is set when its source bit is high while unmasked, and stays set until software clears it. The interrupt line of a group stays high for as long as any pending bit of that group is set.

Software reaches the registers over a simple single-cycle register bus. A request is one cycle of `busValid`. The read data and the error flag come back registered in the following cycle. The register address is not decoded by slicing address bits. A constant table holds one entry per group, giving the input index, the output pin, the output count, the mask word address and the pending word address. The decoder searches this table for an entry whose mask address or pending address matches the request, and an address with no match is an invalid access. This arrangement lets a later group use addresses or pins that follow no formula.

Top module: `intagg_top`

## Requirements
- R1: After reset, every mask and pending register reads as zero, all `irqOut` lines are low, and `busRdata` and `busErr` are zero.
- R2: Addresses are byte offsets in a 0x4000-byte region, with the register window starting at 0x1000. The mask register of group n is at 0x1000 + n*0x100 and its pending register is 4 bytes higher, so group 8 uses 0x1800 and 0x1804. Address bits [1:0] are ignored.
- R3: A write to a mask register replaces its whole value and gives `busErr` = 0. A read returns the register value on `busRdata` in the cycle after the request. No mask register changes without a bus write.
- R4: At each clock edge, a source bit is recorded in its pending bit only when the matching mask bit is 1. Source bits whose mask bit is 0 leave the pending register unchanged.
- R5: A non-zero write to a pending register clears exactly the bits that are 1 in the write data. All other pending bits are left as they are.
- R6: A write of zero to a pending register is rejected. `busErr` is 1 in the following cycle and the pending register is unchanged.
- R7: A request to an address that matches no table entry returns `busRdata` = 0 and raises `busErr` for exactly one cycle, in the cycle after the request. A write to such an address changes no register.
- R8: `irqOut[n]` is high exactly while pending register n is non-zero. It goes low in the cycle after the write that clears the last set bit.
- R9: Clearing a mask bit does not clear a pending bit that is already set.
- R10: If a source bit is high and unmasked in the same cycle that a pending write clears that bit, the bit stays set (setting wins).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register request strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 14 | Byte address within the region |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle after a read request, otherwise zero |
| busErr | output | 1 | One-cycle error flag for an unmatched address or a zero pending write |
| srcIn | input | 9x32 | Source bits, one 32-bit word per group |
| irqOut | output | 9 | Level interrupt line per group |

## Verification
The bench checks that a clearing write with the same source bit still high leaves the bit set. A design that lets the clear win would lose an event that arrived during the write. It checks that turning a mask bit off keeps the latched pending bit, where a design that masks the pending register itself would drop the interrupt line. It writes zero to a pending register, where a careless decoder would treat the write as valid. It also sends accesses to addresses between and beyond the table entries, where a bit-slicing decoder would alias them onto some group and corrupt its registers. Finally, it times the fall of the interrupt line to one cycle after the clearing write and checks that the source bits of masked groups stay invisible.

// File: rtl/intagg_pkg.sv
package intagg_pkg;

  // Index width used in strobes and table entries (covers up to 256 groups).
  localparam int IDX_W  = 8;
  // Width of a word address stored in a table entry.
  localparam int WORD_W = 16;

  // Strobes from the decoder to the register datapath.
  typedef struct packed {
    logic             enWr;      // replace a mask register
    logic             stWr;      // clear pending bits (data already checked non-zero)
    logic             rdReq;     // return a register on the next cycle
    logic             isStatus;  // the matched address is the pending register
    logic [IDX_W-1:0] grp;       // input group selected by the table
  } ctrlStb_t;

  // One row of the constant group map.
  typedef struct packed {
    logic [IDX_W-1:0]  inIdx;
    logic [IDX_W-1:0]  outIdx;
    logic [3:0]        outCnt;
    logic [WORD_W-1:0] enWord;
    logic [WORD_W-1:0] stWord;
  } mapEntry_t;

  // Builds the map row for group g: one source group to one output pin,
  // the mask word at base + g*stride, and the pending word right after it.
  function automatic mapEntry_t mapEntry(int g, int base, int stride);
    mapEntry_t e;
    e.inIdx  = IDX_W'(g);
    e.outIdx = IDX_W'(g);
    e.outCnt = 4'd1;
    e.enWord = WORD_W'((base + g * stride) >> 2);
    e.stWord = WORD_W'(((base + g * stride) >> 2) + 1);
    return e;
  endfunction

endpackage

// File: rtl/intagg_ctrl.sv
module intagg_ctrl
  import intagg_pkg::*;
#(
  parameter int NUM_GROUPS = 9,
  parameter int DATA_W     = 32,
  parameter int BUS_AW     = 14,
  parameter int WIN_BASE   = 'h1000,
  parameter int GRP_STRIDE = 'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output ctrlStb_t          stb,
  output logic              busErr
);

  localparam int WA_W = BUS_AW - 2;

  logic [WA_W-1:0]       wordAddr;
  logic [1:0]            unusedByteBits;
  logic [NUM_GROUPS-1:0] hitEn;
  logic [NUM_GROUPS-1:0] hitSt;
  logic [IDX_W-1:0]      entIn [NUM_GROUPS];

  assign wordAddr       = busAddr[BUS_AW-1:2];
  assign unusedByteBits = busAddr[1:0];

  // One comparator pair per table row.
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_map
    localparam mapEntry_t ENT = mapEntry(g, WIN_BASE, GRP_STRIDE);
    assign hitEn[g] = (wordAddr == ENT.enWord[WA_W-1:0]);
    assign hitSt[g] = (wordAddr == ENT.stWord[WA_W-1:0]);
    assign entIn[g] = ENT.inIdx;
  end

  // Table search: the lowest matching row wins.
  logic             anyHit;
  logic             selStatus;
  logic [IDX_W-1:0] selGrp;

  always_comb begin
    anyHit    = 1'b0;
    selStatus = 1'b0;
    selGrp    = '0;
    for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
      if (hitEn[g] || hitSt[g]) begin
        anyHit    = 1'b1;
        selStatus = hitSt[g];
        selGrp    = entIn[g];
      end
    end
  end

  logic wrReq;
  logic zeroData;
  logic errNow;

  assign wrReq    = busValid && busWrite;
  assign zeroData = (busWdata == '0);

  always_comb begin
    stb.grp      = selGrp;
    stb.isStatus = selStatus;
    stb.enWr     = wrReq && anyHit && !selStatus;
    stb.stWr     = wrReq && anyHit && selStatus && !zeroData;
    stb.rdReq    = busValid && !busWrite && anyHit;
  end

  assign errNow = busValid && (!anyHit || (busWrite && selStatus && zeroData));

  always_ff @(posedge clk) begin
    if (!rstN) busErr <= 1'b0;
    else       busErr <= errNow;
  end

endmodule

// File: rtl/intagg_dp.sv
module intagg_dp
  import intagg_pkg::*;
#(
  parameter int NUM_GROUPS = 9,
  parameter int DATA_W     = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ctrlStb_t                         stb,
  input  logic [DATA_W-1:0]                busWdata,
  input  logic [NUM_GROUPS-1:0][DATA_W-1:0] srcIn,
  output logic [DATA_W-1:0]                busRdata,
  output logic [NUM_GROUPS-1:0]            irqOut,
  output logic [NUM_GROUPS-1:0][DATA_W-1:0] enableVec,
  output logic [NUM_GROUPS-1:0][DATA_W-1:0] statusVec
);

  logic [NUM_GROUPS-1:0] selG;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam mapEntry_t ENT     = mapEntry(g, 0, 0);
    localparam int        OUT_PIN = int'(ENT.outIdx);

    logic [DATA_W-1:0] clrMask;
    logic [DATA_W-1:0] setMask;

    assign selG[g]  = (stb.grp == IDX_W'(g));
    assign clrMask  = (stb.stWr && selG[g]) ? busWdata : '0;
    assign setMask  = srcIn[g] & enableVec[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enableVec[g] <= '0;
        statusVec[g] <= '0;
      end else begin
        if (stb.enWr && selG[g]) enableVec[g] <= busWdata;
        // setting has priority over clearing
        statusVec[g] <= (statusVec[g] & ~clrMask) | setMask;
      end
    end

    assign irqOut[OUT_PIN] = |statusVec[g];
  end

  logic [DATA_W-1:0] rdMux;

  always_comb begin
    rdMux = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (selG[g]) rdMux = stb.isStatus ? statusVec[g] : enableVec[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busRdata <= '0;
    else if (stb.rdReq) busRdata <= rdMux;
    else                busRdata <= '0;
  end

endmodule

// File: rtl/intagg_top.sv
module intagg_top #(
  parameter int NUM_GROUPS = 9,
  parameter int SRC_W      = 32,
  parameter int BUS_AW     = 14,
  parameter int WIN_BASE   = 'h1000,
  parameter int GRP_STRIDE = 'h100
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busValid,
  input  logic                             busWrite,
  input  logic [BUS_AW-1:0]                busAddr,
  input  logic [SRC_W-1:0]                 busWdata,
  output logic [SRC_W-1:0]                 busRdata,
  output logic                             busErr,
  input  logic [NUM_GROUPS-1:0][SRC_W-1:0] srcIn,
  output logic [NUM_GROUPS-1:0]            irqOut
);

  intagg_pkg::ctrlStb_t stb;
  logic [NUM_GROUPS-1:0][SRC_W-1:0] enableVec;
  logic [NUM_GROUPS-1:0][SRC_W-1:0] statusVec;

  intagg_ctrl #(
    .NUM_GROUPS(NUM_GROUPS), .DATA_W(SRC_W), .BUS_AW(BUS_AW),
    .WIN_BASE(WIN_BASE), .GRP_STRIDE(GRP_STRIDE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .stb(stb), .busErr(busErr)
  );

  intagg_dp #(
    .NUM_GROUPS(NUM_GROUPS), .DATA_W(SRC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata), .srcIn(srcIn),
    .busRdata(busRdata), .irqOut(irqOut), .enableVec(enableVec),
    .statusVec(statusVec)
  );

endmodule

// File: rtl/intagg_chk.sv
module intagg_chk #(
  parameter int NUM_GROUPS = 9,
  parameter int SRC_W      = 32
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             busValid,
  input logic                             busWrite,
  input logic [SRC_W-1:0]                 busWdata,
  input logic [SRC_W-1:0]                 busRdata,
  input logic                             busErr,
  input logic [NUM_GROUPS-1:0][SRC_W-1:0] srcIn,
  input logic [NUM_GROUPS-1:0]            irqOut,
  input logic [NUM_GROUPS-1:0][SRC_W-1:0] enableVec,
  input logic [NUM_GROUPS-1:0][SRC_W-1:0] statusVec
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irqOut == '0 && busErr == 1'b0));

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busWrite) |=> $stable(enableVec));

  p_err_follows_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busValid));

  p_err_read_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busErr && $past(!busWrite)) |-> (busRdata == '0));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    p_irq_needs_src_r4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqOut[g]) |-> ($past(srcIn[g] & enableVec[g]) != '0));

    p_no_masked_set_r4: assert property (@(posedge clk) disable iff (!rstN)
      (statusVec[g] & ~$past(statusVec[g]) & ~$past(srcIn[g] & enableVec[g])) == '0);

    p_irq_fall_by_write_r5: assert property (@(posedge clk) disable iff (!rstN)
      $fell(irqOut[g]) |-> $past(busValid && busWrite && busWdata != '0));

    p_no_lost_bit_r9: assert property (@(posedge clk) disable iff (!rstN)
      !$past(busValid && busWrite) |-> (($past(statusVec[g]) & ~statusVec[g]) == '0));
  end

endmodule

bind intagg_top intagg_chk #(.NUM_GROUPS(NUM_GROUPS), .SRC_W(SRC_W)) u_chk (.*);

// File: tb/intagg_top_tb.sv
module intagg_top_tb;

  localparam int NG = 9;
  localparam int W  = 32;
  localparam int AW = 14;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  busValid = 1'b0;
  logic                  busWrite = 1'b0;
  logic [AW-1:0]         busAddr = '0;
  logic [W-1:0]          busWdata = '0;
  logic [W-1:0]          busRdata;
  logic                  busErr;
  logic [NG-1:0][W-1:0]  srcIn = '0;
  logic [NG-1:0]         irqOut;

  int checkCnt = 0;
  int errCnt   = 0;

  always #10 clk = ~clk;  // 50 MHz

  intagg_top u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .srcIn(srcIn), .irqOut(irqOut)
  );

  function automatic logic [AW-1:0] enA(int g);
    return AW'('h1000 + g * 'h100);
  endfunction
  function automatic logic [AW-1:0] stA(int g);
    return AW'('h1000 + g * 'h100 + 4);
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [W-1:0] d, output logic e);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0; busWdata = '0;
    e = busErr;
  endtask

  task automatic doRead(input logic [AW-1:0] a, output logic [W-1:0] d, output logic e);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata; e = busErr;
  endtask

  task automatic pulseSrc(input int g, input logic [W-1:0] v);
    @(negedge clk);
    srcIn[g] = v;
    @(negedge clk);
    srcIn[g] = '0;
  endtask

  task automatic expectReg(input logic [AW-1:0] a, input logic [W-1:0] exp, input string req);
    logic [W-1:0] d; logic e;
    doRead(a, d, e);
    check(d == exp && !e, req, d, exp);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(irqOut == '0, "R1 irq after reset", W'(irqOut), '0);
    check(busRdata == '0 && !busErr, "R1 bus idle after reset", busRdata, '0);
    for (int g = 0; g < NG; g++) begin
      expectReg(enA(g), '0, "R1 mask reset");
      expectReg(stA(g), '0, "R1 pending reset");
    end
  endtask

  task automatic testMap();
    logic e;
    for (int g = 0; g < NG; g++) begin
      doWrite(enA(g), W'(32'hA500_0000 | (g * 'h111)), e);
      check(!e, "R3 mask write accepted", W'(e), '0);
    end
    for (int g = 0; g < NG; g++)
      expectReg(enA(g), W'(32'hA500_0000 | (g * 'h111)), "R2 mask address map");
    expectReg(enA(2) + AW'(2), W'(32'hA500_0222), "R2 low address bits ignored");
    expectReg(stA(8), '0, "R2 pending of group 8 at 0x1804");
    doWrite(enA(4), 32'h0000_0001, e);
    expectReg(enA(4), 32'h0000_0001, "R3 mask write replaces value");
    for (int g = 0; g < NG; g++) doWrite(enA(g), '0, e);
    expectReg(enA(0), '0, "R3 mask cleared by write");
  endtask

  task automatic testLatch();
    logic e;
    doWrite(enA(3), 32'h0000_00F0, e);
    pulseSrc(3, 32'h0000_0FFF);
    check(irqOut == 9'b0_0000_1000, "R8 only group 3 line high", W'(irqOut), 32'h8);
    expectReg(stA(3), 32'h0000_00F0, "R4 only unmasked bits latch");
    pulseSrc(5, 32'hFFFF_FFFF);
    check(irqOut[5] == 1'b0, "R4 fully masked group stays quiet", W'(irqOut[5]), '0);
    expectReg(stA(5), '0, "R4 masked source ignored");
  endtask

  task automatic testClear();
    logic e;
    doWrite(stA(3), 32'h0000_0030, e);
    check(!e, "R5 clear accepted", W'(e), '0);
    expectReg(stA(3), 32'h0000_00C0, "R5 clears only written ones");
    check(irqOut[3] == 1'b1, "R8 line held while bits remain", W'(irqOut[3]), 1);
    doWrite(stA(3), 32'h0000_00C0, e);
    check(irqOut[3] == 1'b0, "R8 line drops cycle after last clear", W'(irqOut[3]), '0);
    expectReg(stA(3), '0, "R5 pending empty");
  endtask

  task automatic testZeroWrite();
    logic e;
    pulseSrc(3, 32'h0000_0010);
    doWrite(stA(3), '0, e);
    check(e == 1'b1, "R6 zero clear flagged", W'(e), 1);
    expectReg(stA(3), 32'h0000_0010, "R6 zero clear has no effect");
    check(irqOut[3] == 1'b1, "R6 line unchanged", W'(irqOut[3]), 1);
    doWrite(stA(3), 32'h0000_0010, e);
  endtask

  task automatic testUnmatched();
    logic [W-1:0] d; logic e;
    doRead(14'h1008, d, e);
    check(d == '0 && e, "R7 read between entries", d, '0);
    @(negedge clk);
    check(busErr == 1'b0, "R7 error lasts one cycle", W'(busErr), '0);
    doWrite(14'h0000, 32'hFFFF_FFFF, e);
    check(e == 1'b1, "R7 write below window flagged", W'(e), 1);
    doWrite(14'h1900, 32'hFFFF_FFFF, e);
    check(e == 1'b1, "R7 write past last entry flagged", W'(e), 1);
    for (int g = 0; g < NG; g++) begin
      expectReg(enA(g), (g == 3) ? 32'h0000_00F0 : '0, "R7 stray writes change no mask");
      expectReg(stA(g), '0, "R7 stray writes change no pending");
    end
  endtask

  task automatic testMaskOff();
    logic e;
    pulseSrc(3, 32'h0000_0080);
    doWrite(enA(3), '0, e);
    expectReg(stA(3), 32'h0000_0080, "R9 pending kept after unmask");
    check(irqOut[3] == 1'b1, "R9 line kept after unmask", W'(irqOut[3]), 1);
    pulseSrc(3, 32'h0000_00F0);
    expectReg(stA(3), 32'h0000_0080, "R4 no new bits when masked");
    doWrite(stA(3), 32'h0000_0080, e);
  endtask

  task automatic testSetWins();
    logic e;
    doWrite(enA(7), 32'h0000_0001, e);
    @(negedge clk);
    srcIn[7] = 32'h0000_0001;
    @(negedge clk);
    doWrite(stA(7), 32'h0000_0001, e);
    expectReg(stA(7), 32'h0000_0001, "R10 set wins over clear");
    check(irqOut[7] == 1'b1, "R10 line stays high", W'(irqOut[7]), 1);
    srcIn[7] = '0;
    doWrite(stA(7), 32'h0000_0001, e);
    expectReg(stA(7), '0, "R5 clear after source drops");
    check(irqOut[7] == 1'b0, "R8 line low after clear", W'(irqOut[7]), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMap();
    testLatch();
    testClear();
    testZeroWrite();
    testUnmatched();
    testMaskOff();
    testSetWins();
    $display("Simulation finished: %0d checks, %0d errors", checkCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checkCnt, errCnt);
    $finish;
  end

endmodule